// File: doc/BRIEF.md
# Fused Multiply-Add NaN Outcome Selector

This block settles which operand supplies the NaN result of a fused multiply-add (a*b)+c. It also says when the default NaN must be produced instead. The caller classifies each of the three operands beforehand. The caller also reports whether the product is infinity times zero, and chooses one of four propagation policies plus a polarity mode for the quiet/signaling bit.

The block returns a 2-bit selection and an invalid-operation flag. Both are purely combinational functions of the inputs. Quieting the chosen NaN and building the final bit pattern are left to the surrounding datapath. Raising invalid for a signaling input is also left to the surrounding datapath.

The policies differ in two ways: the order in which operands are ranked, and how the infinity-times-zero case is treated. For one policy, the polarity mode changes both of these.

Top module: `fma_nan_select`

## Requirements
- R1: Operand class codes are 0 = ordinary number, 1 = quiet NaN, 2 = signaling NaN, 3 = treated as an ordinary number. The selection output is 0 = a, 1 = b, 2 = c, 3 = default NaN. The policy codes are 0 = guarded, 1 = dual, 2 = a-c-b, 3 = plain.
- R2: Under the guarded policy, when infZero is high and c is a quiet NaN, the selection is 3 and invalid is high.
- R3: Under the guarded policy, in all other cases the first matching rule wins: signaling c, signaling a, signaling b, quiet c, quiet a, otherwise b.
- R4: Under the dual policy with legacyNan high, infZero high gives selection 3 and invalid high, whatever the classes are.
- R5: Under the dual policy with legacyNan high and infZero low, the first matching rule wins: signaling a, signaling b, signaling c, quiet a, quiet b, otherwise c.
- R6: Under the dual policy with legacyNan low, infZero high gives selection 2 and invalid high.
- R7: Under the dual policy with legacyNan low and infZero low, the guarded policy's ranking applies: signaling c, a, b, then quiet c, quiet a, otherwise b.
- R8: Under the a-c-b policy, infZero high gives selection 2 and invalid high. Otherwise a is chosen if it is any NaN, then c if it is any NaN, otherwise b.
- R9: Under the plain policy, a is chosen if it is any NaN, then b if it is any NaN, otherwise c. infZero has no effect on either output.
- R10: invalid is high only when infZero is high. Under the guarded policy it additionally requires c to be a quiet NaN. Signaling inputs alone never raise it.
- R11: Under the guarded policy, infZero high with c not a quiet NaN leaves invalid low and the R3 ranking in force.
- R12: legacyNan has no effect under the guarded, a-c-b and plain policies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clsA | input | 2 | Class code of multiplicand a |
| clsB | input | 2 | Class code of multiplier b |
| clsC | input | 2 | Class code of addend c |
| infZero | input | 1 | Product is infinity times zero |
| policy | input | 2 | Propagation policy select |
| legacyNan | input | 1 | Polarity mode: signaling NaNs marked by a set top fraction bit |
| pick | output | 2 | Selected source: a, b, c or default NaN |
| invalid | output | 1 | Invalid-operation flag for the infinity-times-zero case |

## Verification
The bench builds the block with its package defaults: 2-bit class, selection and policy codes over three operands. With these values the whole input space has only 1024 points, so a full sweep reaches every policy, polarity and class mix. That sweep includes the reserved class code and infZero under the plain policy. Seeded random vectors and named corner cases sit on top of the sweep, so that each requirement has its own tagged check.

// File: rtl/fma_nan_pkg.sv
package fma_nan_pkg;
  parameter int CLS_W    = 2;
  parameter int CHOICE_W = 2;
  parameter int POLICY_W = 2;
  parameter int NUM_OPS  = 3;
  localparam int OP_A = 0;
  localparam int OP_B = 1;
  localparam int OP_C = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_NUM  = 2'd0,
    CLS_QNAN = 2'd1,
    CLS_SNAN = 2'd2,
    CLS_RSVD = 2'd3
  } opClass_e;

  typedef enum logic [CHOICE_W-1:0] {
    PICK_A    = 2'd0,
    PICK_B    = 2'd1,
    PICK_C    = 2'd2,
    PICK_DFLT = 2'd3
  } pick_e;

  typedef enum logic [POLICY_W-1:0] {
    POL_GUARDED = 2'd0,
    POL_DUAL    = 2'd1,
    POL_ACB     = 2'd2,
    POL_PLAIN   = 2'd3
  } policy_e;

  // Ranking schemes used by the datapath
  typedef enum logic [1:0] {
    ORD_SIG_CAB = 2'd0,
    ORD_SIG_ABC = 2'd1,
    ORD_ANY_ACB = 2'd2,
    ORD_ANY_ABC = 2'd3
  } order_e;

  typedef struct packed {
    logic   forceDflt;
    logic   forceC;
    logic   invalid;
    order_e order;
  } strobe_t;
endpackage

// File: rtl/fma_nan_ctrl.sv
module fma_nan_ctrl
  import fma_nan_pkg::*;
(
  input  logic [POLICY_W-1:0] policy,
  input  logic                legacyNan,
  input  logic                infZero,
  input  logic [CLS_W-1:0]    clsC,
  output strobe_t             strobes
);
  logic cIsQuiet;
  assign cIsQuiet = (clsC == CLS_QNAN);

  always_comb begin
    strobes = '{forceDflt: 1'b0, forceC: 1'b0, invalid: 1'b0, order: ORD_ANY_ABC};
    case (policy)
      POL_GUARDED: begin
        strobes.order = ORD_SIG_CAB;
        if (infZero && cIsQuiet) begin
          strobes.forceDflt = 1'b1;
          strobes.invalid   = 1'b1;
        end
      end
      POL_DUAL: begin
        if (legacyNan) begin
          strobes.order     = ORD_SIG_ABC;
          strobes.forceDflt = infZero;
        end else begin
          strobes.order  = ORD_SIG_CAB;
          strobes.forceC = infZero;
        end
        strobes.invalid = infZero;
      end
      POL_ACB: begin
        strobes.order   = ORD_ANY_ACB;
        strobes.forceC  = infZero;
        strobes.invalid = infZero;
      end
      default: strobes.order = ORD_ANY_ABC;
    endcase
  end
endmodule

// File: rtl/fma_nan_path.sv
module fma_nan_path
  import fma_nan_pkg::*;
(
  input  logic [CLS_W-1:0]    clsA,
  input  logic [CLS_W-1:0]    clsB,
  input  logic [CLS_W-1:0]    clsC,
  input  strobe_t             strobes,
  output logic [CHOICE_W-1:0] pick
);
  logic [CLS_W-1:0] opCls [NUM_OPS];
  logic [NUM_OPS-1:0] isSig, isQuiet, isAny;

  assign opCls[OP_A] = clsA;
  assign opCls[OP_B] = clsB;
  assign opCls[OP_C] = clsC;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_classify
    assign isSig[i]   = (opCls[i] == CLS_SNAN);
    assign isQuiet[i] = (opCls[i] == CLS_QNAN);
    assign isAny[i]   = isSig[i] | isQuiet[i];
  end

  logic [CHOICE_W-1:0] ranked;

  always_comb begin
    ranked = PICK_C;
    case (strobes.order)
      ORD_SIG_CAB: begin
        if      (isSig[OP_C])   ranked = PICK_C;
        else if (isSig[OP_A])   ranked = PICK_A;
        else if (isSig[OP_B])   ranked = PICK_B;
        else if (isQuiet[OP_C]) ranked = PICK_C;
        else if (isQuiet[OP_A]) ranked = PICK_A;
        else                    ranked = PICK_B;
      end
      ORD_SIG_ABC: begin
        if      (isSig[OP_A])   ranked = PICK_A;
        else if (isSig[OP_B])   ranked = PICK_B;
        else if (isSig[OP_C])   ranked = PICK_C;
        else if (isQuiet[OP_A]) ranked = PICK_A;
        else if (isQuiet[OP_B]) ranked = PICK_B;
        else                    ranked = PICK_C;
      end
      ORD_ANY_ACB: begin
        if      (isAny[OP_A]) ranked = PICK_A;
        else if (isAny[OP_C]) ranked = PICK_C;
        else                  ranked = PICK_B;
      end
      default: begin
        if      (isAny[OP_A]) ranked = PICK_A;
        else if (isAny[OP_B]) ranked = PICK_B;
        else                  ranked = PICK_C;
      end
    endcase
  end

  always_comb begin
    if (strobes.forceDflt)   pick = PICK_DFLT;
    else if (strobes.forceC) pick = PICK_C;
    else                     pick = ranked;
  end
endmodule

// File: rtl/fma_nan_select.sv
module fma_nan_select
  import fma_nan_pkg::*;
(
  input  logic [CLS_W-1:0]    clsA,
  input  logic [CLS_W-1:0]    clsB,
  input  logic [CLS_W-1:0]    clsC,
  input  logic                infZero,
  input  logic [POLICY_W-1:0] policy,
  input  logic                legacyNan,
  output logic [CHOICE_W-1:0] pick,
  output logic                invalid
);
  strobe_t strobes;

  fma_nan_ctrl u_ctrl (
    .policy    (policy),
    .legacyNan (legacyNan),
    .infZero   (infZero),
    .clsC      (clsC),
    .strobes   (strobes)
  );

  fma_nan_path u_path (
    .clsA    (clsA),
    .clsB    (clsB),
    .clsC    (clsC),
    .strobes (strobes),
    .pick    (pick)
  );

  assign invalid = strobes.invalid;
endmodule

// File: rtl/fma_nan_select_chk.sv
module fma_nan_select_chk
  import fma_nan_pkg::*;
(
  input logic [CLS_W-1:0]    clsA,
  input logic [CLS_W-1:0]    clsB,
  input logic [CLS_W-1:0]    clsC,
  input logic                infZero,
  input logic [POLICY_W-1:0] policy,
  input logic                legacyNan,
  input logic [CHOICE_W-1:0] pick,
  input logic                invalid
);
  logic [CLS_W-1:0] pickedCls;
  logic anySig;

  always_comb begin
    case (pick)
      PICK_A:  pickedCls = clsA;
      PICK_B:  pickedCls = clsB;
      PICK_C:  pickedCls = clsC;
      default: pickedCls = CLS_NUM;
    endcase
    anySig = (clsA == CLS_SNAN) || (clsB == CLS_SNAN) || (clsC == CLS_SNAN);
  end

  always_comb begin
    a_r10_invalid_needs_infzero: assert (infZero || !invalid);
    a_r1_default_implies_invalid: assert (pick != PICK_DFLT || invalid);
    a_r9_plain_never_invalid: assert (policy != POL_PLAIN || !invalid);
    a_r3_signaling_wins: assert (!(policy == POL_GUARDED || policy == POL_DUAL)
                                 || invalid || !anySig || pickedCls == CLS_SNAN);
    a_r8_a_nan_first: assert (!(policy == POL_ACB && !invalid
                                && (clsA == CLS_QNAN || clsA == CLS_SNAN))
                              || pick == PICK_A);
  end
endmodule

bind fma_nan_select fma_nan_select_chk u_chk (.*);

// File: tb/fma_nan_select_tb.sv
module fma_nan_select_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic [1:0] clsA = 2'd0, clsB = 2'd0, clsC = 2'd0, policy = 2'd0;
  logic infZero = 1'b0, legacyNan = 1'b0;
  logic [1:0] pick;
  logic invalid;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fma_nan_select u_dut (
    .clsA(clsA), .clsB(clsB), .clsC(clsC), .infZero(infZero),
    .policy(policy), .legacyNan(legacyNan), .pick(pick), .invalid(invalid)
  );

  function automatic bit isN(input logic [1:0] k); return k == 2'd1 || k == 2'd2; endfunction
  function automatic bit isS(input logic [1:0] k); return k == 2'd2; endfunction
  function automatic bit isQ(input logic [1:0] k); return k == 2'd1; endfunction

  // expected {invalid, pick}
  function automatic logic [2:0] refModel(input logic [1:0] a, b, c, pol,
                                          input logic iz, leg);
    logic [1:0] p;
    logic inv = 1'b0;
    if (pol == 2'd3) begin
      p = isN(a) ? 2'd0 : isN(b) ? 2'd1 : 2'd2;
    end else if (pol == 2'd2) begin
      inv = iz;
      p = iz ? 2'd2 : isN(a) ? 2'd0 : isN(c) ? 2'd2 : 2'd1;
    end else if (pol == 2'd1 && leg) begin
      inv = iz;
      if (iz) p = 2'd3;
      else p = isS(a) ? 2'd0 : isS(b) ? 2'd1 : isS(c) ? 2'd2 :
               isQ(a) ? 2'd0 : isQ(b) ? 2'd1 : 2'd2;
    end else begin
      if (pol == 2'd1) inv = iz;
      else inv = iz && isQ(c);
      if (inv) p = (pol == 2'd1) ? 2'd2 : 2'd3;
      else p = isS(c) ? 2'd2 : isS(a) ? 2'd0 : isS(b) ? 2'd1 :
               isQ(c) ? 2'd2 : isQ(a) ? 2'd0 : 2'd1;
    end
    return {inv, p};
  endfunction

  function automatic string reqOf(input logic [1:0] c, pol, input logic iz, leg);
    case (pol)
      2'd0: return (iz && c == 2'd1) ? "R2" : (iz ? "R11" : "R3");
      2'd1: return leg ? (iz ? "R4" : "R5") : (iz ? "R6" : "R7");
      2'd2: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(input logic [1:0] a, b, c, pol, input logic iz, leg,
                       input string req);
    logic [2:0] exp;
    @(posedge clk);
    clsA = a; clsB = b; clsC = c; policy = pol; infZero = iz; legacyNan = leg;
    @(negedge clk);
    exp = refModel(a, b, c, pol, iz, leg);
    checks++;
    if ({invalid, pick} !== exp) begin
      fails++;
      $display("FAIL %s: a=%0d b=%0d c=%0d pol=%0d iz=%0d leg=%0d actual inv=%0d pick=%0d expected inv=%0d pick=%0d",
               req, a, b, c, pol, iz, leg, invalid, pick, exp[2], exp[1:0]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seed = 0;
    // reset-like idle state: all ordinary numbers, plain policy (R1, R10)
    apply(0, 0, 0, 3, 0, 0, "R1");
    // directed corners
    apply(1, 1, 1, 0, 1, 0, "R2");
    apply(2, 2, 1, 0, 1, 0, "R2");
    apply(1, 2, 1, 0, 0, 0, "R3");
    apply(1, 1, 2, 0, 1, 0, "R11");
    apply(0, 0, 0, 1, 1, 1, "R4");
    apply(1, 2, 2, 1, 0, 1, "R5");
    apply(1, 1, 0, 1, 0, 1, "R5");
    apply(0, 0, 0, 1, 1, 0, "R6");
    apply(1, 2, 1, 1, 0, 0, "R7");
    apply(0, 0, 0, 2, 1, 0, "R8");
    apply(0, 2, 1, 2, 0, 0, "R8");
    apply(0, 1, 2, 3, 1, 0, "R9");
    apply(3, 3, 3, 3, 0, 0, "R1");
    apply(1, 1, 1, 0, 1, 1, "R12");
    apply(0, 2, 1, 2, 0, 1, "R12");
    apply(2, 2, 2, 3, 1, 1, "R10");
    // full sweep
    for (int p = 0; p < 4; p++)
      for (int l = 0; l < 2; l++)
        for (int z = 0; z < 2; z++)
          for (int x = 0; x < 64; x++)
            apply(x[5:4], x[3:2], x[1:0], p[1:0], z[0], l[0],
                  reqOf(x[1:0], p[1:0], z[0], l[0]));
    // seeded random
    seed = $urandom(32'd1234);
    for (int i = 0; i < 400; i++) begin
      logic [9:0] r = 10'($urandom);
      apply(r[1:0], r[3:2], r[5:4], r[7:6], r[8], r[9],
            reqOf(r[5:4], r[7:6], r[8], r[9]));
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule